// File: doc/BRIEF.md
# Bus-Inactivity Auto Power-Down Controller

This block watches the address-latch strobe of a processor bus and decides when the bus has gone quiet long enough for the memory side of a chip to be put to sleep. It runs on a separate, slow timeout clock. A four-bit idle counter advances on each timeout-clock edge while the strobe holds one level, whether high or low. A strobe edge clears the counter. When the counter reaches its top value, the power-down indicator rises. A buffer-gate output rises with it and shuts off the address and data input buffers that feed the memories and logic arrays.

Once powered down, the block stays down until one of three wake events occurs: the strobe toggles again, the chip-select-style wake input falls from 1 to 0, or reset is applied. A single enable bit from a mode register arms the whole mechanism. The strobe and the wake input are asynchronous, so each passes through a two-flop synchronizer into the timeout-clock domain, and edges are found on the synchronized samples. The indicator is a registered output, so the chip-select decode and the logic arrays can use it as an ordinary input.

Top module: `idle_pwrdn_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the counter and drives both outputs to 0. After reset is released, with the strobe steady and the block enabled, the indicator rises on the 15th timeout-clock edge.
- R2: While the enable input is 0, the indicator is 0 one edge later and the counter is held at zero. After re-enable, counting restarts from zero, and the indicator rises on the 15th edge.
- R3: With the strobe held low and the block enabled, the indicator stays 0 for 14 timeout-clock edges and becomes 1 on the 15th, when the counter reaches its all-ones value of 15.
- R4: A strobe held steady at logic 1 counts as idle in the same way as a strobe held at logic 0.
- R5: A strobe transition clears the counter, and on the same edge it takes priority over reaching the top value. Strobe toggles spaced 15 timeout-clock edges apart keep the indicator at 0. A gap of 16 or more edges lets it rise.
- R6: Once the indicator is 1, it stays 1 and the counter saturates without wrapping, for as long as no wake event occurs and the block stays enabled.
- R7: A strobe transition while powered down clears the indicator on the third timeout-clock edge after the change: two synchronizer stages, then one edge-compare stage.
- R8: A 1-to-0 transition of the wake input while powered down clears the indicator on the third edge after the change. A rising wake edge, or a falling wake edge while not powered down, leaves the counting unchanged.
- R9: The buffer-gate output always equals the power-down indicator (1 = input buffers disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tmo | input | 1 | Slow timeout clock; all state is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| apd_en | input | 1 | Enable bit from the mode register, synchronous to clk_tmo |
| bus_strobe | input | 1 | Asynchronous address-latch strobe; any edge is bus activity |
| wake_sel | input | 1 | Asynchronous chip-select-style wake input; a falling edge wakes |
| pwr_dn | output | 1 | Registered power-down indicator |
| bus_gate_off | output | 1 | Registered gate; 1 disables the address/data input buffers |

## Verification
The assertions assume that the enable bit is already synchronous to the timeout clock and that each strobe or wake level stays put for at least one timeout-clock period, so that the synchronizers can see every edge. They also assume that the strobe is low while reset is released, since the synchronizers reset to 0 and a high strobe would look like a spurious edge. The stimulus changes every input one nanosecond after a rising edge and holds it for whole periods. Before each reset it returns the strobe to 0, and it changes the enable bit only between edges of the same clock.

// File: rtl/apd_pkg.sv
package apd_pkg;
  // Activity events seen in the timeout-clock domain
  typedef struct packed {
    logic strobe_edge;  // synchronized strobe changed level
    logic wake_fall;    // synchronized wake input went 1 -> 0
  } apd_evt_t;
endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/apd_activity.sv
module apd_activity
  import apd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     strobe_s,
  input  logic     wake_s,
  output apd_evt_t evt
);
  logic strobe_q;
  logic wake_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_s;
      wake_q   <= wake_s;
    end
  end

  always_comb begin
    evt.strobe_edge = strobe_s ^ strobe_q;
    evt.wake_fall   = wake_q & ~wake_s;
  end
endmodule

// File: rtl/apd_idle_cnt.sv
module apd_idle_cnt
  import apd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  apd_evt_t         evt,
  output logic [CNT_W-1:0] cnt,
  output logic             pd,
  output logic             gate
);
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_TOP - 1'b1;

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             pd_q, pd_nx, gate_q;

  always_comb begin
    cnt_nx = cnt_q;
    pd_nx  = pd_q;
    if (!en) begin
      cnt_nx = '0;
      pd_nx  = 1'b0;
    end else if (pd_q) begin
      if (evt.strobe_edge || evt.wake_fall) begin
        cnt_nx = '0;
        pd_nx  = 1'b0;
      end
    end else if (evt.strobe_edge) begin
      cnt_nx = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_nx = CNT_TOP;
      pd_nx  = 1'b1;
    end else begin
      cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pd_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      pd_q   <= pd_nx;
      gate_q <= pd_nx;
    end
  end

  assign cnt  = cnt_q;
  assign pd   = pd_q;
  assign gate = gate_q;
endmodule

// File: rtl/idle_pwrdn_ctrl.sv
module idle_pwrdn_ctrl
  import apd_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_tmo,
  input  logic rst,
  input  logic apd_en,
  input  logic bus_strobe,
  input  logic wake_sel,
  output logic pwr_dn,
  output logic bus_gate_off
);
  logic             strobe_s;
  logic             wake_s;
  apd_evt_t         evt;
  logic [CNT_W-1:0] idle_cnt;

  apd_sync #(.STAGES(SYNC_STAGES)) u_sync_strobe (
    .clk(clk_tmo), .rst(rst), .d(bus_strobe), .q(strobe_s)
  );

  apd_sync #(.STAGES(SYNC_STAGES)) u_sync_wake (
    .clk(clk_tmo), .rst(rst), .d(wake_sel), .q(wake_s)
  );

  apd_activity u_act (
    .clk(clk_tmo), .rst(rst), .strobe_s(strobe_s), .wake_s(wake_s), .evt(evt)
  );

  apd_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_tmo), .rst(rst), .en(apd_en), .evt(evt),
    .cnt(idle_cnt), .pd(pwr_dn), .gate(bus_gate_off)
  );
endmodule

// File: rtl/idle_pwrdn_ctrl_chk.sv
module idle_pwrdn_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             pwr_dn,
  input logic             gate,
  input logic             strobe_edge,
  input logic             wake_fall,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_TOP - 1'b1;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!pwr_dn && !gate && cnt == '0));

  assert_disable_forces_low_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwr_dn && cnt == '0));

  assert_rise_at_top_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_dn) |-> ($past(cnt) == CNT_LAST && $past(en)));

  assert_edge_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe_edge && !pwr_dn) |=> (cnt == '0 && !pwr_dn));

  assert_hold_saturate_R6: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn && en && !strobe_edge && !wake_fall) |=> (pwr_dn && cnt == CNT_TOP));

  assert_strobe_wakes_R7: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn && strobe_edge) |=> !pwr_dn);

  assert_wake_fall_wakes_R8: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn && wake_fall) |=> !pwr_dn);

  assert_gate_tracks_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_dn) |-> $rose(gate));
endmodule

bind idle_pwrdn_ctrl idle_pwrdn_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk_tmo), .rst(rst), .en(apd_en), .pwr_dn(pwr_dn), .gate(bus_gate_off),
  .strobe_edge(evt.strobe_edge), .wake_fall(evt.wake_fall), .cnt(idle_cnt)
);

// File: tb/idle_pwrdn_ctrl_tb_top.sv
`timescale 1ns/1ps
module idle_pwrdn_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic strobe = 1'b0;
  logic wake = 1'b1;
  logic pd, gate;

  int n_run = 0;
  int n_fail = 0;
  bit exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  idle_pwrdn_ctrl dut_i (
    .clk_tmo(clk), .rst(rst), .apd_en(en), .bus_strobe(strobe),
    .wake_sel(wake), .pwr_dn(pd), .bus_gate_off(gate)
  );

  // Driver: one rising edge, then queue the expected indicator after it
  task automatic tick(input bit e, input string tag);
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic ticks(input int n, input bit e, input string tag);
    for (int i = 0; i < n; i++) tick(e, tag);
  endtask

  // Monitor: compare away from the active edge; gate is checked for R9
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (pd !== e) begin
        n_fail++;
        $display("FAIL %s: pwr_dn=%b expected %b at %0t", t, pd, e, $time);
      end else if (gate !== e) begin
        n_fail++;
        $display("FAIL R9: bus_gate_off=%b expected %b at %0t", gate, e, $time);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    ticks(4, 1'b0, "R1");
    rst = 1'b0;
    // R3: 14 idle edges low, 15th raises the indicator
    ticks(14, 1'b0, "R3");
    tick(1'b1, "R3");
    // R6: saturates, no wrap
    ticks(20, 1'b1, "R6");
    // R8: wake falling exits on third edge
    wake = 1'b0;
    ticks(2, 1'b1, "R8");
    tick(1'b0, "R8");
    wake = 1'b1;  // rising wake: no effect, count resumes from 0
    ticks(14, 1'b0, "R8");
    tick(1'b1, "R8");
    // R7: strobe edge exits on third edge
    strobe = 1'b1;
    ticks(2, 1'b1, "R7");
    tick(1'b0, "R7");
    // R4: strobe held high counts as idle; R8 wake fall while awake ignored
    ticks(5, 1'b0, "R4");
    wake = 1'b0;
    ticks(9, 1'b0, "R8");
    tick(1'b1, "R4");
    wake = 1'b1;
    strobe = 1'b0;
    ticks(2, 1'b1, "R7");
    tick(1'b0, "R7");
    // R5: toggles 15 edges apart never power down; a 16+ gap does
    ticks(12, 1'b0, "R5");
    for (int k = 0; k < 6; k++) begin
      strobe = ~strobe;
      ticks(15, 1'b0, "R5");
    end
    ticks(2, 1'b0, "R5");
    tick(1'b1, "R5");
    // R2: disable forces low and holds; re-enable counts from zero
    en = 1'b0;
    tick(1'b0, "R2");
    ticks(30, 1'b0, "R2");
    en = 1'b1;
    ticks(14, 1'b0, "R2");
    tick(1'b1, "R2");
    // R1: reset while powered down, then restart counting
    rst = 1'b1;
    tick(1'b0, "R1");
    ticks(3, 1'b0, "R1");
    rst = 1'b0;
    ticks(14, 1'b0, "R1");
    tick(1'b1, "R1");
    @(negedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule